// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits on the I/O side of a host bridge and turns the classic two-port configuration scheme into single config-space requests. Software first writes a 32-bit selector dword to the address port (0xCF8). This selector holds an enable bit, a bus number, a device/function number and a register offset. Software then reads or writes through a four-byte data window at ports 0xCFC to 0xCFF. The decoder keeps the selector in a register and checks each data-window access for size and alignment. It adds the byte lane to the offset and forwards the access over a valid/ready request channel. Read data comes back on a response-valid strobe.

Only one bus/devfn pair can be reached. The pair is sampled from static inputs in the first clock after reset. An enabled access aimed at any other pair is fatal: the block sets a sticky halt flag, issues no request, and stops taking I/O accesses until the next reset. Accesses that are disabled, misaligned or not decoded finish locally: reads return all ones and writes do nothing.

Top module: `cfg_window_decode`

## Requirements
- R1: After reset, halt_o is low, cfg_req_valid_o is low and a dword read of port 0xCF8 returns 0.
- R2: A dword (size 4) write to port 0xCF8 stores the full 32-bit selector, and a dword read of 0xCF8 returns the stored value.
- R3: While selector bit 31 is 0, data-window reads return 32'hFFFFFFFF and data-window writes issue no request.
- R4: A forwarded request carries bus = selector[23:16], devfn = selector[15:8], offset = (selector[7:0] + port - 0xCFC) mod 256, the access size and the write flag.
- R5: Sizes are encoded 1, 2 or 4 bytes. Bytes are legal at 0xCFC to 0xCFF, words only at 0xCFC and 0xCFE, and dwords only at 0xCFC. Any other size or position reads all ones and issues no request.
- R6: An enabled, legal data-window access whose bus or devfn differs from the own target raises halt_o, issues no request and completes with all ones.
- R7: Once raised, halt_o stays high and io_ready_o stays low until reset.
- R8: For a forwarded write, cfg_req_wdata_o carries the low size bytes of io_wdata_i, and its upper bytes are zero.
- R9: For a forwarded read, io_rdata_o on io_done_o equals cfg_rsp_data_i masked to the low size bytes.
- R10: While cfg_req_valid_o is high and cfg_req_ready_i is low, the request stays valid and unchanged, and io_ready_o stays low.
- R11: The own bus and devfn come from own_bus_i and own_devfn_i in the first clock after reset. Later changes on those inputs have no effect until the next reset.
- R12: Ports outside 0xCF8 and the data window, and non-dword accesses at 0xCF8, read all ones, and writes to them leave the selector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| own_bus_i | input | 8 | Static own-target bus number |
| own_devfn_i | input | 8 | Static own-target device/function |
| io_req_i | input | 1 | I/O access request, accepted when io_ready_o is high |
| io_we_i | input | 1 | 1 = write, 0 = read |
| io_port_i | input | PORT_W | I/O port address |
| io_size_i | input | 3 | Access size in bytes (1, 2, 4) |
| io_wdata_i | input | 32 | Write data, right-aligned |
| io_ready_o | output | 1 | Block can accept an access |
| io_done_o | output | 1 | One-cycle completion pulse |
| io_rdata_o | output | 32 | Read data, valid with io_done_o |
| halt_o | output | 1 | Sticky fatal foreign-target flag |
| cfg_req_valid_o | output | 1 | Config request valid |
| cfg_req_ready_i | input | 1 | Config request accepted |
| cfg_req_we_o | output | 1 | Request is a write |
| cfg_req_size_o | output | 3 | Request size in bytes |
| cfg_req_bus_o | output | 8 | Request bus number |
| cfg_req_devfn_o | output | 8 | Request device/function |
| cfg_req_offset_o | output | 8 | Request register offset |
| cfg_req_wdata_o | output | 32 | Request write data |
| cfg_rsp_valid_i | input | 1 | Read response valid |
| cfg_rsp_data_i | input | 32 | Read response data |

## Verification
The bench aims at offset arithmetic at the byte lanes, including wrap past 0xFF. A design that ignored the lane would send a byte at 0xCFE to the base offset, and one that widened the sum would lose the wrap. It runs every illegal size and lane pair. A decoder that accepted a word at 0xCFD or a dword at 0xCFE would issue a request instead of returning all ones. It also checks that the own target is frozen after reset, that a foreign target halts the block for good, and that a stalled request holds. A design that re-read the static inputs, let the halt clear, or accepted new I/O during a stall would each show up at the ports.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned EN_BIT = 31;

  typedef enum logic [2:0] {
    K_NONE, K_ADDR_WR, K_ADDR_RD, K_FWD, K_HALT
  } acc_kind_e;

  typedef enum logic [1:0] {
    S_LOAD, S_IDLE, S_REQ, S_RSP
  } xfer_state_e;

  typedef struct packed {
    logic          we;
    logic [2:0]    size;
    logic [7:0]    bus;
    logic [7:0]    devfn;
    logic [7:0]    offset;
    logic [DW-1:0] wdata;
  } cfg_req_t;

  function automatic logic [DW-1:0] size_mask(input logic [2:0] sz);
    logic [DW-1:0] m;
    for (int b = 0; b < DW/8; b++) m[8*b +: 8] = (b < int'(sz)) ? 8'hFF : 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/cfgw_addr_reg.sv
module cfgw_addr_reg
  import cfgw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] value_o,
  output logic          map_en_o,
  output logic [7:0]    bus_o,
  output logic [7:0]    devfn_o,
  output logic [7:0]    offset_o
);
  logic [DW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (wr_en_i) sel_q <= wdata_i;
  end

  assign value_o  = sel_q;
  assign map_en_o = sel_q[EN_BIT];
  assign bus_o    = sel_q[23:16];
  assign devfn_o  = sel_q[15:8];
  assign offset_o = sel_q[7:0];
endmodule

// File: rtl/cfgw_port_decode.sv
module cfgw_port_decode
  import cfgw_pkg::*;
#(
  parameter int unsigned       PORT_W    = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [PORT_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic [PORT_W-1:0] port_i,
  input  logic [2:0]        size_i,
  input  logic              we_i,
  input  logic              map_en_i,
  input  logic [7:0]        bus_i,
  input  logic [7:0]        devfn_i,
  input  logic [7:0]        offset_i,
  input  logic [7:0]        own_bus_i,
  input  logic [7:0]        own_devfn_i,
  output acc_kind_e         kind_o,
  output logic [7:0]        eff_off_o
);
  localparam logic [PORT_W-1:0] WIN_SPAN = PORT_W'(DW/8);

  logic [PORT_W-1:0] diff;
  logic [1:0]        lane;
  logic              in_win, aligned, own_hit;

  assign diff    = port_i - DATA_PORT;
  assign lane    = diff[1:0];
  assign in_win  = (port_i >= DATA_PORT) && (diff < WIN_SPAN);
  assign own_hit = (bus_i == own_bus_i) && (devfn_i == own_devfn_i);

  always_comb begin
    unique case (size_i)
      3'd1:    aligned = 1'b1;
      3'd2:    aligned = ~lane[0];
      3'd4:    aligned = (lane == 2'd0);
      default: aligned = 1'b0;
    endcase
  end

  always_comb begin
    kind_o = K_NONE;
    if (port_i == ADDR_PORT && size_i == 3'd4)
      kind_o = we_i ? K_ADDR_WR : K_ADDR_RD;
    else if (in_win && aligned && map_en_i)
      kind_o = own_hit ? K_FWD : K_HALT;
  end

  assign eff_off_o = offset_i + {6'd0, lane};
endmodule

// File: rtl/cfgw_xfer.sv
module cfgw_xfer
  import cfgw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          io_req_i,
  input  acc_kind_e     kind_i,
  input  cfg_req_t      req_i,
  input  logic [DW-1:0] addr_val_i,
  output logic          io_ready_o,
  output logic          io_done_o,
  output logic [DW-1:0] io_rdata_o,
  output logic          addr_wr_o,
  output logic          loading_o,
  output logic          halt_o,
  output logic          cfg_valid_o,
  output cfg_req_t      cfg_req_o,
  input  logic          cfg_ready_i,
  input  logic          cfg_rsp_valid_i,
  input  logic [DW-1:0] cfg_rsp_data_i
);
  xfer_state_e   state_q;
  cfg_req_t      req_q;
  logic          halt_q, done_q, accept;
  logic [DW-1:0] rdata_q;

  assign io_ready_o  = (state_q == S_IDLE) && !halt_q;
  assign accept      = io_req_i && io_ready_o;
  assign addr_wr_o   = accept && (kind_i == K_ADDR_WR);
  assign loading_o   = (state_q == S_LOAD);
  assign cfg_valid_o = (state_q == S_REQ);
  assign cfg_req_o   = req_q;
  assign io_done_o   = done_q;
  assign io_rdata_o  = rdata_q;
  assign halt_o      = halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_LOAD;
      req_q   <= '0;
      halt_q  <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_LOAD: state_q <= S_IDLE;
        S_IDLE: if (accept) begin
          unique case (kind_i)
            K_ADDR_WR: begin done_q <= 1'b1; rdata_q <= '0; end
            K_ADDR_RD: begin done_q <= 1'b1; rdata_q <= addr_val_i; end
            K_FWD:     begin req_q <= req_i; state_q <= S_REQ; end
            K_HALT:    begin halt_q <= 1'b1; done_q <= 1'b1; rdata_q <= '1; end
            default:   begin done_q <= 1'b1; rdata_q <= '1; end
          endcase
        end
        S_REQ: if (cfg_ready_i) begin
          if (req_q.we) begin
            done_q  <= 1'b1;
            rdata_q <= '0;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_RSP;
          end
        end
        S_RSP: if (cfg_rsp_valid_i) begin
          done_q  <= 1'b1;
          rdata_q <= cfg_rsp_data_i & size_mask(req_q.size);
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_window_decode.sv
module cfg_window_decode
  import cfgw_pkg::*;
#(
  parameter int unsigned       PORT_W    = 16,
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [PORT_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        own_bus_i,
  input  logic [7:0]        own_devfn_i,
  input  logic              io_req_i,
  input  logic              io_we_i,
  input  logic [PORT_W-1:0] io_port_i,
  input  logic [2:0]        io_size_i,
  input  logic [31:0]       io_wdata_i,
  output logic              io_ready_o,
  output logic              io_done_o,
  output logic [31:0]       io_rdata_o,
  output logic              halt_o,
  output logic              cfg_req_valid_o,
  input  logic              cfg_req_ready_i,
  output logic              cfg_req_we_o,
  output logic [2:0]        cfg_req_size_o,
  output logic [7:0]        cfg_req_bus_o,
  output logic [7:0]        cfg_req_devfn_o,
  output logic [7:0]        cfg_req_offset_o,
  output logic [31:0]       cfg_req_wdata_o,
  input  logic              cfg_rsp_valid_i,
  input  logic [31:0]       cfg_rsp_data_i
);
  logic [DW-1:0] sel_val;
  logic          map_en, addr_wr, loading;
  logic [7:0]    sel_bus, sel_devfn, sel_off, eff_off;
  logic [7:0]    own_bus_q, own_devfn_q;
  acc_kind_e     kind;
  cfg_req_t      req_new, req_out;

  // own target frozen in the first clock after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_bus_q   <= '0;
      own_devfn_q <= '0;
    end else if (loading) begin
      own_bus_q   <= own_bus_i;
      own_devfn_q <= own_devfn_i;
    end
  end

  cfgw_addr_reg u_sel (
    .clk_i, .rst_ni,
    .wr_en_i (addr_wr),
    .wdata_i (io_wdata_i),
    .value_o (sel_val),
    .map_en_o(map_en),
    .bus_o   (sel_bus),
    .devfn_o (sel_devfn),
    .offset_o(sel_off)
  );

  cfgw_port_decode #(.PORT_W(PORT_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .port_i     (io_port_i),
    .size_i     (io_size_i),
    .we_i       (io_we_i),
    .map_en_i   (map_en),
    .bus_i      (sel_bus),
    .devfn_i    (sel_devfn),
    .offset_i   (sel_off),
    .own_bus_i  (own_bus_q),
    .own_devfn_i(own_devfn_q),
    .kind_o     (kind),
    .eff_off_o  (eff_off)
  );

  always_comb begin
    req_new.we     = io_we_i;
    req_new.size   = io_size_i;
    req_new.bus    = sel_bus;
    req_new.devfn  = sel_devfn;
    req_new.offset = eff_off;
    req_new.wdata  = io_wdata_i & size_mask(io_size_i);
  end

  cfgw_xfer u_xfer (
    .clk_i, .rst_ni,
    .io_req_i       (io_req_i),
    .kind_i         (kind),
    .req_i          (req_new),
    .addr_val_i     (sel_val),
    .io_ready_o     (io_ready_o),
    .io_done_o      (io_done_o),
    .io_rdata_o     (io_rdata_o),
    .addr_wr_o      (addr_wr),
    .loading_o      (loading),
    .halt_o         (halt_o),
    .cfg_valid_o    (cfg_req_valid_o),
    .cfg_req_o      (req_out),
    .cfg_ready_i    (cfg_req_ready_i),
    .cfg_rsp_valid_i(cfg_rsp_valid_i),
    .cfg_rsp_data_i (cfg_rsp_data_i)
  );

  assign cfg_req_we_o     = req_out.we;
  assign cfg_req_size_o   = req_out.size;
  assign cfg_req_bus_o    = req_out.bus;
  assign cfg_req_devfn_o  = req_out.devfn;
  assign cfg_req_offset_o = req_out.offset;
  assign cfg_req_wdata_o  = req_out.wdata;
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_ready_o,
  input logic        halt_o,
  input logic        cfg_req_valid_o,
  input logic        cfg_req_ready_i,
  input logic        cfg_req_we_o,
  input logic [2:0]  cfg_req_size_o,
  input logic [7:0]  cfg_req_bus_o,
  input logic [7:0]  cfg_req_devfn_o,
  input logic [7:0]  cfg_req_offset_o,
  input logic [31:0] cfg_req_wdata_o,
  input logic [7:0]  own_bus_q,
  input logic [7:0]  own_devfn_q
);
  p_halt_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  p_halt_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !io_ready_o);
  p_no_req_halt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !cfg_req_valid_o);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_valid_o && !cfg_req_ready_i) |=> (cfg_req_valid_o && $stable(cfg_req_offset_o)
      && $stable(cfg_req_bus_o) && $stable(cfg_req_devfn_o) && $stable(cfg_req_wdata_o)
      && $stable(cfg_req_size_o) && $stable(cfg_req_we_o)));
  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_valid_o |-> !io_ready_o);
  p_target_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_valid_o |-> (cfg_req_bus_o == own_bus_q && cfg_req_devfn_o == own_devfn_q));
  p_size_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_valid_o |-> ($onehot(cfg_req_size_o) && cfg_req_size_o != 3'd0));
  p_wmask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_valid_o && cfg_req_we_o && cfg_req_size_o != 3'd4) |-> (cfg_req_wdata_o[31:16] == 16'd0));
endmodule

bind cfg_window_decode cfgw_checker u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .io_ready_o      (io_ready_o),
  .halt_o          (halt_o),
  .cfg_req_valid_o (cfg_req_valid_o),
  .cfg_req_ready_i (cfg_req_ready_i),
  .cfg_req_we_o    (cfg_req_we_o),
  .cfg_req_size_o  (cfg_req_size_o),
  .cfg_req_bus_o   (cfg_req_bus_o),
  .cfg_req_devfn_o (cfg_req_devfn_o),
  .cfg_req_offset_o(cfg_req_offset_o),
  .cfg_req_wdata_o (cfg_req_wdata_o),
  .own_bus_q       (own_bus_q),
  .own_devfn_q     (own_devfn_q)
);

// File: tb/cfg_window_decode_test.sv
module cfg_window_decode_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  own_bus_i = 8'h05, own_devfn_i = 8'h18;
  logic        io_req_i = 1'b0, io_we_i = 1'b0;
  logic [15:0] io_port_i = '0;
  logic [2:0]  io_size_i = '0;
  logic [31:0] io_wdata_i = '0;
  logic        io_ready_o, io_done_o, halt_o;
  logic [31:0] io_rdata_o;
  logic        cfg_req_valid_o, cfg_req_ready_i = 1'b0, cfg_req_we_o;
  logic [2:0]  cfg_req_size_o;
  logic [7:0]  cfg_req_bus_o, cfg_req_devfn_o, cfg_req_offset_o;
  logic [31:0] cfg_req_wdata_o;
  logic        cfg_rsp_valid_i = 1'b0;
  logic [31:0] cfg_rsp_data_i = '0;

  int checks = 0, errors = 0;
  int req_count = 0, stall = 0, stall_cnt = 0, busy_err = 0;
  logic        pend_rd = 1'b0;
  logic [7:0]  last_off, last_bus, last_devfn;
  logic [2:0]  last_size;
  logic        last_we;
  logic [31:0] last_wdata;

  always #10 clk_i = ~clk_i;

  cfg_window_decode uut (.*);

  function automatic logic [31:0] rsp_word(input logic [7:0] off);
    return {8'h5A, off ^ 8'h3C, off, 8'hE1};
  endfunction

  // config-space responder model
  always @(negedge clk_i) begin
    cfg_req_ready_i = 1'b0;
    cfg_rsp_valid_i = 1'b0;
    if (pend_rd) begin
      cfg_rsp_valid_i = 1'b1;
      cfg_rsp_data_i  = rsp_word(last_off);
      pend_rd = 1'b0;
    end else if (cfg_req_valid_o) begin
      if (stall_cnt >= stall) begin
        cfg_req_ready_i = 1'b1;
        stall_cnt  = 0;
        req_count++;
        last_off   = cfg_req_offset_o;
        last_bus   = cfg_req_bus_o;
        last_devfn = cfg_req_devfn_o;
        last_size  = cfg_req_size_o;
        last_we    = cfg_req_we_o;
        last_wdata = cfg_req_wdata_o;
        if (!cfg_req_we_o) pend_rd = 1'b1;
      end else stall_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_io(input logic we, input logic [15:0] port, input logic [2:0] size,
                       input logic [31:0] wd, output logic [31:0] rd);
    int guard = 0;
    while (!io_ready_o && guard < 1000) begin @(negedge clk_i); guard++; end
    io_req_i = 1'b1; io_we_i = we; io_port_i = port; io_size_i = size; io_wdata_i = wd;
    @(negedge clk_i);
    io_req_i = 1'b0;
    guard = 0;
    while (!io_done_o && guard < 1000) begin
      if (cfg_req_valid_o && io_ready_o) busy_err++;
      @(negedge clk_i); guard++;
    end
    rd = io_rdata_o;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    do_reset();
    check("R1 halt", 32'(halt_o), 32'd0);
    check("R1 req_valid", 32'(cfg_req_valid_o), 32'd0);
    do_io(1'b0, 16'h0CF8, 3'd4, 32'd0, rd);
    check("R1 selector", rd, 32'd0);
  endtask

  task automatic t_sel_reg();
    logic [31:0] rd;
    do_io(1'b1, 16'h0CF8, 3'd4, 32'h7A5C_3E91, rd);
    do_io(1'b0, 16'h0CF8, 3'd4, 32'd0, rd);
    check("R2 readback", rd, 32'h7A5C_3E91);
  endtask

  task automatic t_disabled();
    logic [31:0] rd;
    int n0;
    do_io(1'b1, 16'h0CF8, 3'd4, 32'h0005_1840, rd);
    n0 = req_count;
    do_io(1'b0, 16'h0CFC, 3'd4, 32'd0, rd);
    check("R3 read ones", rd, 32'hFFFF_FFFF);
    do_io(1'b1, 16'h0CFC, 3'd4, 32'h1234_5678, rd);
    check("R3 no request", 32'(req_count - n0), 32'd0);
  endtask

  task automatic t_forward();
    logic [31:0] rd;
    do_io(1'b1, 16'h0CF8, 3'd4, 32'h8005_1840, rd);
    do_io(1'b0, 16'h0CFE, 3'd1, 32'd0, rd);
    check("R4 offset lane2", 32'(last_off), 32'h42);
    check("R4 bus", 32'(last_bus), 32'h05);
    check("R4 devfn", 32'(last_devfn), 32'h18);
    check("R4 size/we", {28'd0, last_we, last_size}, 32'h1);
    check("R9 byte read", rd, rsp_word(8'h42) & 32'hFF);
    do_io(1'b1, 16'h0CFE, 3'd2, 32'hDEAD_BEEF, rd);
    check("R4 word write", {20'd0, last_we, last_size, last_off}, 32'h0000_0A42);
    check("R8 word data", last_wdata, 32'h0000_BEEF);
    do_io(1'b1, 16'h0CFD, 3'd1, 32'hCAFE_F00D, rd);
    check("R8 byte data", last_wdata, 32'h0000_000D);
    do_io(1'b0, 16'h0CFC, 3'd4, 32'd0, rd);
    check("R9 dword read", rd, rsp_word(8'h40));
    do_io(1'b0, 16'h0CFE, 3'd2, 32'd0, rd);
    check("R9 word read", rd, rsp_word(8'h42) & 32'hFFFF);
    do_io(1'b1, 16'h0CF8, 3'd4, 32'h8005_18FF, rd);
    do_io(1'b0, 16'h0CFD, 3'd1, 32'd0, rd);
    check("R4 offset wrap", 32'(last_off), 32'h00);
  endtask

  task automatic t_align();
    logic [31:0] rd;
    int n0;
    do_io(1'b1, 16'h0CF8, 3'd4, 32'h8005_1810, rd);
    n0 = req_count;
    do_io(1'b0, 16'h0CFD, 3'd2, 32'd0, rd);
    check("R5 word at CFD", rd, 32'hFFFF_FFFF);
    do_io(1'b0, 16'h0CFE, 3'd4, 32'd0, rd);
    check("R5 dword at CFE", rd, 32'hFFFF_FFFF);
    do_io(1'b0, 16'h0CFC, 3'd3, 32'd0, rd);
    check("R5 size 3", rd, 32'hFFFF_FFFF);
    do_io(1'b1, 16'h0CFF, 3'd2, 32'd0, rd);
    check("R5 no request", 32'(req_count - n0), 32'd0);
    do_io(1'b0, 16'h0CFF, 3'd1, 32'd0, rd);
    check("R5 byte at CFF", 32'(last_off), 32'h13);
  endtask

  task automatic t_other_ports();
    logic [31:0] rd;
    do_io(1'b1, 16'h0CF8, 3'd4, 32'h8005_1820, rd);
    do_io(1'b1, 16'h0CF8, 3'd2, 32'h0000_1111, rd);
    do_io(1'b1, 16'h0CF9, 3'd4, 32'h2222_2222, rd);
    do_io(1'b1, 16'h0080, 3'd4, 32'h3333_3333, rd);
    do_io(1'b0, 16'h0CF8, 3'd4, 32'd0, rd);
    check("R12 selector kept", rd, 32'h8005_1820);
    do_io(1'b0, 16'h0080, 3'd1, 32'd0, rd);
    check("R12 other port read", rd, 32'hFFFF_FFFF);
    do_io(1'b0, 16'h0CF8, 3'd1, 32'd0, rd);
    check("R12 byte at CF8", rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_stall();
    logic [31:0] rd;
    stall = 3; busy_err = 0;
    do_io(1'b0, 16'h0CFC, 3'd4, 32'd0, rd);
    check("R10 dword under stall", rd, rsp_word(8'h20));
    check("R10 ready low while busy", 32'(busy_err), 32'd0);
    stall = 0;
  endtask

  task automatic t_own_frozen();
    logic [31:0] rd;
    int n0;
    own_bus_i = 8'h07;
    @(negedge clk_i);
    do_io(1'b1, 16'h0CF8, 3'd4, 32'h8005_1804, rd);
    n0 = req_count;
    do_io(1'b0, 16'h0CFC, 3'd1, 32'd0, rd);
    check("R11 old target still served", 32'(req_count - n0), 32'd1);
    check("R11 no halt", 32'(halt_o), 32'd0);
  endtask

  task automatic t_halt();
    logic [31:0] rd;
    int n0;
    do_io(1'b1, 16'h0CF8, 3'd4, 32'h8007_1804, rd);
    n0 = req_count;
    do_io(1'b0, 16'h0CFC, 3'd4, 32'd0, rd);
    check("R6 read ones", rd, 32'hFFFF_FFFF);
    check("R6 halt raised", 32'(halt_o), 32'd1);
    check("R6 no request", 32'(req_count - n0), 32'd0);
    repeat (5) @(negedge clk_i);
    check("R7 halt sticky", 32'(halt_o), 32'd1);
    check("R7 ready held low", 32'(io_ready_o), 32'd0);
    own_bus_i = 8'h07;
    do_reset();
    check("R7 halt cleared by reset", 32'(halt_o), 32'd0);
    do_io(1'b1, 16'h0CF8, 3'd4, 32'h8007_1808, rd);
    do_io(1'b0, 16'h0CFC, 3'd4, 32'd0, rd);
    check("R11 new target after reset", rd, rsp_word(8'h08));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sel_reg();
    t_disabled();
    t_forward();
    t_align();
    t_other_ports();
    t_stall();
    t_own_frozen();
    t_halt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule